// File: doc/BRIEF.md
# Receive segment address translator

This block sits on the inbound side of a chip-to-chip memory bridge. Each address that arrives from the far device carries, in its upper bits, a segment index, a privilege index and a security bit packed together by the sender. A selector register tells the block which bit slices hold each of these fields. The fields may overlap in the address.

The segment index reads a 64-entry segment table. Each entry holds the upper 16 bits of a local base address and a 5-bit length code. The block masks the received address down to an offset inside that segment and adds the base. The privilege index reads a 16-entry table of 4-bit privilege IDs. The security bit is mapped to an output level by two control bits in the selector register. All results are registered one cycle after the input.

Software configures the block over a small register bus. Both tables are reached only through index/value register pairs. A write to a value register stores into the entry named by the matching index register. A read of a value register returns that entry.

Top module: `seg_addr_xlate`

## Requirements
- R1: The selector register at offset 0x2C holds the segment select in bits 3:0, the privilege select in bits 11:8, the security select in bits 19:16, the low security level in bit 24 and the high security level in bit 25. All other bits read as 0.
- R2: Offset 0x38 holds a 6-bit segment index in bits 5:0. Offset 0x30 holds a 4-bit privilege index in bits 3:0. A write to 0x3C stores base = data[31:16] and length code = data[4:0] into the segment entry at the current segment index. A write to 0x34 stores data[3:0] into the privilege entry at the current privilege index. Reads of 0x3C and 0x34 return the entry at the current index in the same bit positions, with unused bits 0. Any other offset reads 0.
- R3: A segment select of 0 gives segment index 0. A segment select of n (1..15) gives index = received address bits starting at bit n+16, at most 6 bits wide, clipped at bit 31.
- R4: A privilege select of 0 gives privilege index 0. A privilege select of n (1..15) gives index = received address bits starting at bit n+16, at most 4 bits wide, clipped at bit 31.
- R5: With security select 0 the security output equals the low level bit. With security select n (1..15), received address bit n+16 picks the high level bit when 1 and the low level bit when 0.
- R6: For a length code c of 8 to 31, the output address is (base << 16) + (received address AND (2^(c+1) − 1)), modulo 2^32. Code 31 keeps the whole received address.
- R7: A length code of 0 to 7 sets the error output to 1 and the output address to 0. Any other code gives error 0.
- R8: The privilege output is the privilege table entry selected by the privilege index.
- R9: Results appear with the valid output exactly one cycle after an input marked valid, so back-to-back inputs give back-to-back results. In a cycle after an input not marked valid, the valid output is 0 and the data outputs hold their last values.
- R10: A register or table write in the same cycle as a valid input does not affect that input's result. It applies from the next valid input.
- R11: After reset, the valid and error outputs are 0 and every register and table entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| in_valid | input | 1 | Received address is valid this cycle |
| in_addr | input | 32 | Received address |
| out_valid | output | 1 | Translated result valid |
| out_addr | output | 32 | Translated local address |
| out_priv | output | 4 | Privilege ID |
| out_sec | output | 1 | Security flag |
| out_err | output | 1 | Lookup hit an empty segment |

## Verification
Every translated result is due on the clock edge after the cycle in which its address is presented. The driver pushes the expected result into a queue in the same cycle it raises the input valid. The monitor pops and compares one item per valid output at each falling edge. A result that arrives early, late or without a matching input therefore shows up as an empty or left-over queue entry.

Register read data is combinational, so readback is sampled shortly after the offset is driven. Writes that coincide with a valid input are modelled by computing that input's expected result before the shadow tables are updated.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int ADDR_W    = 32;
    localparam int FIELD_LSB = 16;
    localparam int SEL_W     = 4;
    localparam int BASE_W    = 16;
    localparam int CODE_W    = 5;
    localparam int PRIV_W    = 4;
    localparam int CFG_AW    = 8;
    localparam int CFG_DW    = 32;
    localparam int MIN_CODE  = 8;

    localparam logic [CFG_AW-1:0] OFS_SEL  = 8'h2C;
    localparam logic [CFG_AW-1:0] OFS_PIDX = 8'h30;
    localparam logic [CFG_AW-1:0] OFS_PVAL = 8'h34;
    localparam logic [CFG_AW-1:0] OFS_SIDX = 8'h38;
    localparam logic [CFG_AW-1:0] OFS_SVAL = 8'h3C;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [CODE_W-1:0] code;
    } seg_ent_t;

    typedef struct packed {
        logic             sec_hi;
        logic             sec_lo;
        logic [SEL_W-1:0] sec_sel;
        logic [SEL_W-1:0] priv_sel;
        logic [SEL_W-1:0] seg_sel;
    } sel_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [PRIV_W-1:0] priv;
        logic              sec;
        logic              err;
    } out_t;
endpackage

// File: rtl/xlate_slice.sv
module xlate_slice
    import xlate_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEL_W-1:0]  sel,
    output logic [IDX_W-1:0]  idx
);
    // Shifting right leaves only the bits at and above the chosen low bit,
    // so slices near bit 31 are clipped on their own.
    always_comb begin
        if (sel == '0) begin
            idx = '0;
        end else begin
            idx = IDX_W'(addr >> (FIELD_LSB + int'(sel)));
        end
    end
endmodule

// File: rtl/xlate_regs.sv
module xlate_regs
    import xlate_pkg::*;
#(
    parameter int SEG_ENTRIES  = 64,
    parameter int PRIV_ENTRIES = 16,
    localparam int SEG_IW  = $clog2(SEG_ENTRIES),
    localparam int PRIV_IW = $clog2(PRIV_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [CFG_DW-1:0]  cfg_wdata,
    output logic [CFG_DW-1:0]  cfg_rdata,
    output sel_t               sel_o,
    input  logic [SEG_IW-1:0]  seg_lk_idx,
    output seg_ent_t           seg_lk_ent,
    input  logic [PRIV_IW-1:0] priv_lk_idx,
    output logic [PRIV_W-1:0]  priv_lk_val
);
    typedef struct packed {
        sel_t               sel;
        logic [PRIV_IW-1:0] pidx;
        logic [SEG_IW-1:0]  sidx;
    } regs_t;

    regs_t             r_d, r_q;
    seg_ent_t          seg_tab_d  [SEG_ENTRIES];
    seg_ent_t          seg_tab_q  [SEG_ENTRIES];
    logic [PRIV_W-1:0] priv_tab_d [PRIV_ENTRIES];
    logic [PRIV_W-1:0] priv_tab_q [PRIV_ENTRIES];
    logic              wdata_unused;

    assign wdata_unused = ^{cfg_wdata[15:12], cfg_wdata[7:5]};

    // Next-state for registers and tables
    always_comb begin
        r_d        = r_q;
        seg_tab_d  = seg_tab_q;
        priv_tab_d = priv_tab_q;
        if (cfg_we) begin
            case (cfg_addr)
                OFS_SEL: begin
                    r_d.sel.seg_sel  = cfg_wdata[3:0];
                    r_d.sel.priv_sel = cfg_wdata[11:8];
                    r_d.sel.sec_sel  = cfg_wdata[19:16];
                    r_d.sel.sec_lo   = cfg_wdata[24];
                    r_d.sel.sec_hi   = cfg_wdata[25];
                end
                OFS_PIDX: r_d.pidx = cfg_wdata[PRIV_IW-1:0];
                OFS_SIDX: r_d.sidx = cfg_wdata[SEG_IW-1:0];
                OFS_PVAL: priv_tab_d[r_q.pidx] = cfg_wdata[PRIV_W-1:0];
                OFS_SVAL: begin
                    seg_tab_d[r_q.sidx].base = cfg_wdata[CFG_DW-1 -: BASE_W];
                    seg_tab_d[r_q.sidx].code = cfg_wdata[CODE_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            seg_tab_q  <= '{default: '0};
            priv_tab_q <= '{default: '0};
        end else begin
            r_q        <= r_d;
            seg_tab_q  <= seg_tab_d;
            priv_tab_q <= priv_tab_d;
        end
    end

    // Read mux
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            OFS_SEL: begin
                cfg_rdata[3:0]   = r_q.sel.seg_sel;
                cfg_rdata[11:8]  = r_q.sel.priv_sel;
                cfg_rdata[19:16] = r_q.sel.sec_sel;
                cfg_rdata[24]    = r_q.sel.sec_lo;
                cfg_rdata[25]    = r_q.sel.sec_hi;
            end
            OFS_PIDX: cfg_rdata[PRIV_IW-1:0] = r_q.pidx;
            OFS_SIDX: cfg_rdata[SEG_IW-1:0]  = r_q.sidx;
            OFS_PVAL: cfg_rdata[PRIV_W-1:0]  = priv_tab_q[r_q.pidx];
            OFS_SVAL: begin
                cfg_rdata[CFG_DW-1 -: BASE_W] = seg_tab_q[r_q.sidx].base;
                cfg_rdata[CODE_W-1:0]         = seg_tab_q[r_q.sidx].code;
            end
            default: ;
        endcase
    end

    assign sel_o       = r_q.sel;
    assign seg_lk_ent  = seg_tab_q[seg_lk_idx];
    assign priv_lk_val = priv_tab_q[priv_lk_idx];

    AST_PIDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == OFS_PIDX) |=> (r_q.pidx == $past(cfg_wdata[PRIV_IW-1:0]))); // R2
    AST_SIDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == OFS_SIDX) |=> (r_q.sidx == $past(cfg_wdata[SEG_IW-1:0]))); // R2
endmodule

// File: rtl/seg_addr_xlate.sv
module seg_addr_xlate
    import xlate_pkg::*;
#(
    parameter int SEG_ENTRIES  = 64,
    parameter int PRIV_ENTRIES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [CFG_DW-1:0]    cfg_wdata,
    output logic [CFG_DW-1:0]    cfg_rdata,
    input  logic                 in_valid,
    input  logic [ADDR_W-1:0]    in_addr,
    output logic                 out_valid,
    output logic [ADDR_W-1:0]    out_addr,
    output logic [PRIV_W-1:0]    out_priv,
    output logic                 out_sec,
    output logic                 out_err
);
    localparam int SEG_IW  = $clog2(SEG_ENTRIES);
    localparam int PRIV_IW = $clog2(PRIV_ENTRIES);

    sel_t               sel;
    logic [SEG_IW-1:0]  seg_idx;
    logic [PRIV_IW-1:0] priv_idx;
    logic               sec_bit;
    seg_ent_t           seg_ent;
    logic [PRIV_W-1:0]  priv_val;
    logic [ADDR_W-1:0]  off_mask;
    logic               seg_hit;
    out_t               o_d, o_q;

    xlate_regs #(
        .SEG_ENTRIES (SEG_ENTRIES),
        .PRIV_ENTRIES(PRIV_ENTRIES)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .sel_o      (sel),
        .seg_lk_idx (seg_idx),
        .seg_lk_ent (seg_ent),
        .priv_lk_idx(priv_idx),
        .priv_lk_val(priv_val)
    );

    xlate_slice #(.IDX_W(SEG_IW)) u_seg_pick (
        .addr(in_addr), .sel(sel.seg_sel), .idx(seg_idx)
    );

    xlate_slice #(.IDX_W(PRIV_IW)) u_priv_pick (
        .addr(in_addr), .sel(sel.priv_sel), .idx(priv_idx)
    );

    xlate_slice #(.IDX_W(1)) u_sec_pick (
        .addr(in_addr), .sel(sel.sec_sel), .idx(sec_bit)
    );

    // Next-state of the output stage
    always_comb begin
        if (int'(seg_ent.code) + 1 >= ADDR_W) begin
            off_mask = '1;
        end else begin
            off_mask = (ADDR_W'(1) << (int'(seg_ent.code) + 1)) - ADDR_W'(1);
        end
        seg_hit = (seg_ent.code >= CODE_W'(MIN_CODE));

        o_d       = o_q;
        o_d.valid = in_valid;
        if (in_valid) begin
            o_d.err  = !seg_hit;
            o_d.addr = seg_hit ? ({seg_ent.base, {(ADDR_W-BASE_W){1'b0}}} + (in_addr & off_mask))
                               : '0;
            o_d.priv = priv_val;
            if (sel.sec_sel == '0) begin
                o_d.sec = sel.sec_lo;
            end else begin
                o_d.sec = sec_bit ? sel.sec_hi : sel.sec_lo;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.valid;
    assign out_addr  = o_q.addr;
    assign out_priv  = o_q.priv;
    assign out_sec   = o_q.sec;
    assign out_err   = o_q.err;

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_addr) && $stable(out_priv))); // R9
    AST_ERR_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_addr == '0)); // R7
    AST_EMPTY_SEG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seg_ent.code < CODE_W'(MIN_CODE)) |=> out_err); // R7
    AST_SEC_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel.sec_sel == '0) |=> (out_sec == $past(sel.sec_lo))); // R5
endmodule

// File: tb/test_seg_addr_xlate.sv
module test_seg_addr_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [3:0]  out_priv;
    logic        out_sec;
    logic        out_err;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [31:0] a;
        logic [3:0]  p;
        logic        s;
        logic        e;
        string       tag;
    } exp_t;
    exp_t exq[$];

    // shadow of programmed state
    logic [15:0] sh_base [64];
    logic [4:0]  sh_code [64];
    logic [3:0]  sh_priv [16];
    logic [3:0]  sh_segsel, sh_privsel, sh_secsel;
    logic        sh_lo, sh_hi;
    logic [5:0]  sh_sidx;
    logic [3:0]  sh_pidx;

    seg_addr_xlate i_seg_addr_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_addr(in_addr), .out_valid(out_valid), .out_addr(out_addr),
        .out_priv(out_priv), .out_sec(out_sec), .out_err(out_err)
    );

    always #10 clk = ~clk;

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] field(input logic [31:0] a, input logic [3:0] n,
                                          input int w);
        logic [31:0] v;
        if (n == 0) return 32'h0;
        v = a >> (16 + n);
        return v & ((32'h1 << w) - 1);
    endfunction

    function automatic exp_t model(input logic [31:0] a, input string tag);
        exp_t r;
        int si, pi, c;
        logic [31:0] m;
        si = int'(field(a, sh_segsel, 6));
        pi = int'(field(a, sh_privsel, 4));
        c  = int'(sh_code[si]);
        r.tag = tag;
        r.p = sh_priv[pi];
        if (sh_secsel == 0) r.s = sh_lo;
        else r.s = a[16 + int'(sh_secsel)] ? sh_hi : sh_lo;
        if (c < 8) begin
            r.e = 1'b1; r.a = 32'h0;
        end else begin
            r.e = 1'b0;
            m = (c == 31) ? 32'hFFFF_FFFF : ((32'h1 << (c + 1)) - 1);
            r.a = {sh_base[si], 16'h0} + (a & m);
        end
        return r;
    endfunction

    function automatic void shadow_write(input logic [7:0] ofs, input logic [31:0] d);
        case (ofs)
            8'h2C: begin
                sh_segsel = d[3:0]; sh_privsel = d[11:8]; sh_secsel = d[19:16];
                sh_lo = d[24]; sh_hi = d[25];
            end
            8'h30: sh_pidx = d[3:0];
            8'h34: sh_priv[sh_pidx] = d[3:0];
            8'h38: sh_sidx = d[5:0];
            8'h3C: begin sh_base[sh_sidx] = d[31:16]; sh_code[sh_sidx] = d[4:0]; end
            default: ;
        endcase
    endfunction

    task automatic wr(input logic [7:0] ofs, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = d;
        shadow_write(ofs, d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [31:0] a, input string tag);
        exq.push_back(model(a, tag));
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_exp(input logic [31:0] a, input logic [31:0] ea,
                            input logic [3:0] ep, input string tag);
        exp_t r;
        r.a = ea; r.p = ep; r.s = 1'b0; r.e = 1'b0; r.tag = tag;
        exq.push_back(r);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_wr(input logic [31:0] a, input logic [7:0] ofs,
                           input logic [31:0] d, input string tag);
        exq.push_back(model(a, tag));
        shadow_write(ofs, d);
        in_valid = 1'b1; in_addr = a;
        cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = d;
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_check(input logic [7:0] ofs, input logic [31:0] exp, input string tag);
        cfg_addr = ofs;
        #1;
        check(cfg_rdata == exp, tag, cfg_rdata, exp);
        @(negedge clk);
    endtask

    task automatic set_seg(input int i, input logic [15:0] b, input logic [4:0] c);
        wr(8'h38, 32'(i));
        wr(8'h3C, {b, 11'h0, c});
    endtask

    task automatic set_priv(input int i, input logic [3:0] v);
        wr(8'h30, 32'(i));
        wr(8'h34, {28'h0, v});
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exq.size() == 0) begin
                tests++; fails++;
                $display("FAIL R9 unexpected result actual=0x%08h expected=none", out_addr);
            end else begin
                exp_t e;
                e = exq.pop_front();
                check(out_addr == e.a, {e.tag, " addr"}, out_addr, e.a);
                check(out_priv == e.p, {e.tag, " priv (R8)"}, 32'(out_priv), 32'(e.p));
                check(out_sec == e.s, {e.tag, " sec"}, 32'(out_sec), 32'(e.s));
                check(out_err == e.e, {e.tag, " err (R7)"}, 32'(out_err), 32'(e.e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] held;
        for (int i = 0; i < 64; i++) begin sh_base[i] = '0; sh_code[i] = '0; end
        for (int i = 0; i < 16; i++) sh_priv[i] = '0;
        sh_segsel = 0; sh_privsel = 0; sh_secsel = 0; sh_lo = 0; sh_hi = 0;
        sh_sidx = 0; sh_pidx = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check(out_valid == 1'b0, "R11 out_valid after reset", 32'(out_valid), 0);
        check(out_err == 1'b0, "R11 out_err after reset", 32'(out_err), 0);
        rd_check(8'h2C, 0, "R11 selector reset");
        rd_check(8'h3C, 0, "R11 segment entry reset");
        rd_check(8'h34, 0, "R11 privilege entry reset");

        // R1 selector layout, reserved bits read zero
        wr(8'h2C, 32'hFFFF_FFFF);
        rd_check(8'h2C, 32'h030F_0F0F, "R1 selector fields");
        // R2 unused bits, unknown offset
        wr(8'h38, 32'hFFFF_FFC5);
        rd_check(8'h38, 32'h0000_0005, "R2 segment index width");
        wr(8'h3C, 32'hFFFF_FFFF);
        rd_check(8'h3C, 32'hFFFF_001F, "R2 segment value fields");
        wr(8'h30, 32'h0000_00F9);
        wr(8'h34, 32'hFFFF_FFF6);
        rd_check(8'h34, 32'h0000_0006, "R2 privilege value field");
        rd_check(8'h00, 32'h0, "R2 unknown offset reads zero");
        set_seg(5, 16'h0000, 5'd0);

        // Scenario: one 256 MB segment repeated, privilege by top nibble
        wr(8'h2C, 32'h0000_0C0C);
        for (int i = 0; i < 64; i++) set_seg(i, 16'h8000, 5'd27);
        for (int i = 0; i < 16; i++) set_priv(i, (i < 8) ? 4'hD : 4'hE);
        wr(8'h38, 32'd17);
        rd_check(8'h3C, 32'h8000_001B, "R2 segment readback");
        send_exp(32'h5567_89A0, 32'h8567_89A0, 4'hD, "R6 256MB segment");
        send(32'hB123_4567, "R6 R8 privilege E");
        idle(2);

        // Scenario: 16 MB segments at index bits 29:24, empty rows -> error
        wr(8'h2C, 32'h0000_0C08);
        for (int i = 0; i < 64; i++) begin
            if ((i % 16) < 8) set_seg(i, 16'h8000 + 16'(16'h0200 * (i % 16)), 5'd23);
            else set_seg(i, 16'h0000, 5'd0);
        end
        send_exp(32'h7567_89A0, 32'h8A67_89A0, 4'hD, "R3 R6 16MB segment");
        send(32'h0867_89A0, "R7 empty segment");
        send(32'hC167_89A0, "R3 overlapping slices");
        idle(1);
        check(out_valid == 1'b0, "R9 valid drops after stream", 32'(out_valid), 0);
        held = out_addr;
        idle(3);
        check(out_addr == held, "R9 outputs hold while idle", out_addr, held);

        // R3/R4 boundary selects: identity privilege table exposes the index
        for (int i = 0; i < 64; i++) set_seg(i, 16'h1000 + 16'(i), 5'd15);
        for (int i = 0; i < 16; i++) set_priv(i, 4'(i));
        foreach (sh_code[k]) ;
        for (int n = 0; n < 16; n++) begin
            wr(8'h2C, {20'h0, 4'(15 - n), 4'h0, 4'(n)});
            send(32'hA5C3_1234, "R3 R4 select sweep");
            send(32'h5A3C_FEDC, "R3 R4 select sweep");
        end
        idle(2);

        // R5 security mapping
        wr(8'h2C, 32'h0200_0000);
        send(32'hFFFF_FFFF, "R5 unselected low level 0");
        wr(8'h2C, 32'h0104_0000);
        send(32'h0010_0000, "R5 bit20 set picks high");
        send(32'h0000_0000, "R5 bit20 clear picks low");
        wr(8'h2C, 32'h020F_0000);
        send(32'h8000_0000, "R5 bit31 set picks high");
        send(32'h7FFF_FFFF, "R5 bit31 clear picks low");
        idle(2);

        // R6/R7 code edges
        wr(8'h2C, 32'h0);
        set_seg(0, 16'h0001, 5'd31);
        send_exp(32'hFFFF_0000, 32'h0000_0000, 4'h0, "R6 code 31 wraps");
        set_seg(0, 16'h1234, 5'd8);
        send_exp(32'hFFFF_FFFF, 32'h1234_01FF, 4'h0, "R6 code 8 512B");
        set_seg(0, 16'h4000, 5'd7);
        send(32'h0000_0010, "R7 code 7 is empty");
        idle(2);

        // R10 writes concurrent with traffic
        set_seg(0, 16'hA000, 5'd15);
        send_wr(32'h0000_1111, 8'h3C, 32'hB000_000F, "R10 old segment entry");
        send(32'h0000_2222, "R10 new segment entry");
        send_wr(32'h0013_3333, 8'h2C, 32'h0304_0000, "R10 old selector");
        send(32'h0013_3333, "R10 new selector");
        idle(3);

        check(exq.size() == 0, "R9 all results delivered", 32'(exq.size()), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule